// File: doc/BRIEF.md
# Time-Triggered Cycle Trigger Scheduler

This block walks an ordered list of time triggers once per basic cycle and turns each trigger into an action at the moment its time mark comes due. A local cycle timer advances on every network time unit tick and is cleared when the reference message's start-of-frame sample point is signalled. At that point the block also latches the cycle count carried by the reference message. Each trigger holds a kind, a message number, a 7-bit repetition code and a 16-bit time mark. The repetition code decides in which basic cycles the trigger takes part.

The scan visits one trigger per clock. Triggers that do not apply to the current cycle are passed over silently. Triggers that are badly configured are passed over with an error pulse. A due trigger emits a one-clock action carrying its kind, message number and the cycle time at which it fired. An end-of-list entry halts the scan until the next reference start.

The block also counts message-transmit actions over a matrix cycle. When a new matrix cycle begins, it compares that count with an expected value supplied on a port. The trigger list is loaded through a plain write port.

Top module: `tt_trigger_sched`

## Requirements
- R1: A write with `wr_en` high stores kind, message number, repetition code and time mark at `wr_addr`. Kind codes are 0 end-of-list, 1 reference transmit, 2 message transmit, 3 receive check and 4 watch timeout. After reset every entry reads as end-of-list.
- R2: `cyc_time` counts up by one on each clock with `ntu_tick` high. A clock with `sof_sync` high clears it to 0 instead, and that clock also latches `sof_cycle` as the current cycle count.
- R3: Triggers are visited in address order starting at address 0 after each `sof_sync`. The head trigger waits until `cyc_time` reaches its time mark. A due trigger gives a one-clock `act_valid` with `act_kind`, `act_msg` and `act_time` equal to the mark.
- R4: A repetition code applies when its highest set bit is at position k and the current cycle count mod 2^k equals the code's k low bits. For example, 0b001cccc applies every 16th cycle, 0b01ccccc every 32nd, 0b1cccccc every 64th, and 0b0000001 every cycle. A code of zero never applies.
- R5: A trigger whose repetition code does not apply to the current cycle is skipped with no action and no error.
- R6: A trigger that applies but has a time mark less than or equal to `ref_len` gives a one-clock `cfg_err` pulse and no action.
- R7: A reference-transmit trigger whose message number is not 1 gives a one-clock `cfg_err` pulse and no action.
- R8: An end-of-list entry stops the scan. Entries stored after it never act until the next `sof_sync`.
- R9: At a `sof_sync` with `sof_cycle` equal to 0 (after the first one), `tx_err` is loaded with whether the number of message-transmit actions since the previous such point differs from `exp_tx`. The count then restarts.
- R10: After reset `act_valid`, `cfg_err`, `tx_err` and `cyc_time` are 0, and no action occurs before the first `sof_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Trigger write strobe |
| wr_addr | input | AW | Trigger write address |
| wr_kind | input | 3 | Trigger kind code |
| wr_msg | input | MSG_W | Trigger message number |
| wr_code | input | 7 | Trigger repetition code |
| wr_mark | input | 16 | Trigger time mark |
| ntu_tick | input | 1 | One network time unit has elapsed |
| sof_sync | input | 1 | Reference start-of-frame sample point |
| sof_cycle | input | 6 | Cycle count of the starting basic cycle |
| ref_len | input | 16 | Reference message length in time units |
| exp_tx | input | CNT_W | Expected transmit actions per matrix cycle |
| act_valid | output | 1 | Action pulse |
| act_kind | output | 3 | Kind of the action |
| act_msg | output | MSG_W | Message number of the action |
| act_time | output | 16 | Cycle time at which the action fired |
| cfg_err | output | 1 | Configuration error pulse |
| tx_err | output | 1 | Transmit count mismatch at last matrix boundary |
| cyc_time | output | 16 | Current cycle time |

## Verification
On every cycle the embedded properties check four things: that the timer clears after a reference start and steps by one on a tick; that no action carries a time at or below the reference length; that a reference-transmit action always names message 1; and that an action and an error pulse never coincide. The bench scenarios have to show everything else. That covers list order, the repetition-code decoding across cycle counts 0, 1, 2, 3, 5 and 19, the silence of entries beyond the end marker, and the matrix-boundary count comparison in both its matching and mismatching outcomes.

// File: rtl/tt_sched_pkg.sv
package tt_sched_pkg;
    parameter int MSG_W  = 6;
    parameter int MARK_W = 16;
    parameter int CODE_W = 7;
    parameter int CCNT_W = 6;

    typedef enum logic [2:0] {
        TRG_END   = 3'd0,
        TRG_TXREF = 3'd1,
        TRG_TXMSG = 3'd2,
        TRG_RXCHK = 3'd3,
        TRG_WATCH = 3'd4
    } trg_kind_e;

    typedef struct packed {
        trg_kind_e         kind;
        logic [MSG_W-1:0]  msg;
        logic [CODE_W-1:0] code;
        logic [MARK_W-1:0] mark;
    } trg_entry_t;
endpackage

// File: rtl/tt_cycle_match.sv
module tt_cycle_match
    import tt_sched_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [CCNT_W-1:0] cnt,
    output logic              hit
);
    logic              found;
    logic [CCNT_W-1:0] msk;

    // The highest set bit selects the period; the bits below it give the offset.
    always_comb begin
        hit   = 1'b0;
        found = 1'b0;
        msk   = '0;
        for (int k = CODE_W - 1; k >= 0; k--) begin
            if (!found && code[k]) begin
                found = 1'b1;
                msk   = CCNT_W'((1 << k) - 1);
                hit   = ((cnt ^ code[CCNT_W-1:0]) & msk) == '0;
            end
        end
    end
endmodule

// File: rtl/tt_trig_mem.sv
module tt_trig_mem
    import tt_sched_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [AW-1:0] wr_addr,
    input  trg_entry_t wr_data,
    input  logic [AW-1:0] rd_addr,
    output trg_entry_t rd_data
);
    trg_entry_t mem_q [DEPTH];
    trg_entry_t mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (wr_en) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/tt_trigger_sched.sv
module tt_trigger_sched
    import tt_sched_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [2:0]        wr_kind,
    input  logic [MSG_W-1:0]  wr_msg,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [MARK_W-1:0] wr_mark,
    input  logic              ntu_tick,
    input  logic              sof_sync,
    input  logic [CCNT_W-1:0] sof_cycle,
    input  logic [MARK_W-1:0] ref_len,
    input  logic [CNT_W-1:0]  exp_tx,
    output logic              act_valid,
    output logic [2:0]        act_kind,
    output logic [MSG_W-1:0]  act_msg,
    output logic [MARK_W-1:0] act_time,
    output logic              cfg_err,
    output logic              tx_err,
    output logic [MARK_W-1:0] cyc_time
);
    typedef struct packed {
        logic [MARK_W-1:0] cyc_time;
        logic [CCNT_W-1:0] cyc_cnt;
        logic [AW-1:0]     ptr;
        logic              running;
        logic              started;
        logic [CNT_W-1:0]  tx_cnt;
        logic              tx_err;
        logic              act_valid;
        trg_kind_e         act_kind;
        logic [MSG_W-1:0]  act_msg;
        logic [MARK_W-1:0] act_time;
        logic              cfg_err;
    } sched_t;

    sched_t     st_q, st_d;
    trg_entry_t head, wr_entry;
    logic       code_hit;
    logic       advance;

    assign wr_entry = '{kind: trg_kind_e'(wr_kind), msg: wr_msg, code: wr_code, mark: wr_mark};

    tt_trig_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_entry),
        .rd_addr (st_q.ptr),
        .rd_data (head)
    );

    tt_cycle_match u_match (
        .code (head.code),
        .cnt  (st_q.cyc_cnt),
        .hit  (code_hit)
    );

    always_comb begin
        st_d           = st_q;
        st_d.act_valid = 1'b0;
        st_d.cfg_err   = 1'b0;
        advance        = 1'b0;
        if (ntu_tick && st_q.cyc_time != '1) st_d.cyc_time = st_q.cyc_time + 1'b1;
        if (sof_sync) begin
            st_d.cyc_time = '0;
            st_d.cyc_cnt  = sof_cycle;
            st_d.ptr      = '0;
            st_d.running  = 1'b1;
            st_d.started  = 1'b1;
            if (!st_q.started) begin
                st_d.tx_cnt = '0;
            end else if (sof_cycle == '0) begin
                st_d.tx_err = st_q.tx_cnt != exp_tx;
                st_d.tx_cnt = '0;
            end
        end else if (st_q.running) begin
            if (head.kind == TRG_END) begin
                st_d.running = 1'b0;
            end else if (!code_hit) begin
                advance = 1'b1;
            end else if (head.mark <= ref_len ||
                         (head.kind == TRG_TXREF && head.msg != MSG_W'(1))) begin
                st_d.cfg_err = 1'b1;
                advance      = 1'b1;
            end else if (st_q.cyc_time >= head.mark) begin
                st_d.act_valid = 1'b1;
                st_d.act_kind  = head.kind;
                st_d.act_msg   = head.msg;
                st_d.act_time  = st_q.cyc_time;
                if (head.kind == TRG_TXMSG) st_d.tx_cnt = st_q.tx_cnt + 1'b1;
                advance = 1'b1;
            end
            if (advance) begin
                if (st_q.ptr == AW'(DEPTH - 1)) st_d.running = 1'b0;
                else                            st_d.ptr     = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_valid = st_q.act_valid;
    assign act_kind  = st_q.act_kind;
    assign act_msg   = st_q.act_msg;
    assign act_time  = st_q.act_time;
    assign cfg_err   = st_q.cfg_err;
    assign tx_err    = st_q.tx_err;
    assign cyc_time  = st_q.cyc_time;

    // R2
    sof_clears_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_sync |=> cyc_time == '0);
    // R2
    tick_steps_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ntu_tick && !sof_sync && cyc_time != '1) |=> cyc_time == $past(cyc_time) + 1'b1);
    // R6
    act_above_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> act_time > ref_len);
    // R7
    ref_msg_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_kind == 3'd1) |-> act_msg == MSG_W'(1));
    // R3
    act_xor_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_valid && cfg_err));
endmodule

// File: tb/sim_tt_trigger_sched.sv
module sim_tt_trigger_sched;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [2:0]  wr_kind = '0;
    logic [5:0]  wr_msg = '0;
    logic [6:0]  wr_code = '0;
    logic [15:0] wr_mark = '0;
    logic        ntu_tick = 1'b0;
    logic        sof_sync = 1'b0;
    logic [5:0]  sof_cycle = '0;
    logic [15:0] ref_len = 16'd10;
    logic [7:0]  exp_tx = '0;
    logic        act_valid;
    logic [2:0]  act_kind;
    logic [5:0]  act_msg;
    logic [15:0] act_time;
    logic        cfg_err;
    logic        tx_err;
    logic [15:0] cyc_time;

    int n_cmp = 0;
    int n_bad = 0;
    int cfg_seen = 0;
    int cfg_exp = 0;
    int tx_model = 0;
    logic [24:0] exp_q [$];

    logic [2:0]  t_kind [DEPTH];
    logic [5:0]  t_msg  [DEPTH];
    logic [6:0]  t_code [DEPTH];
    logic [15:0] t_mark [DEPTH];

    tt_trigger_sched #(.DEPTH(DEPTH), .CNT_W(8)) u0 (.*);

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit code_applies(input logic [6:0] code, input int cnt);
        for (int p = 6; p >= 0; p--) begin
            if ((int'(code) >> p) == 1) return (cnt % (1 << p)) == (int'(code) % (1 << p));
        end
        return 1'b0;
    endfunction

    // Monitor: pops the scoreboard on every action
    always @(negedge clk) begin
        if (rst_n && act_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R5 unexpected action", int'(act_msg), -1);
            end else begin
                logic [24:0] e;
                e = exp_q.pop_front();
                check({act_kind, act_msg, act_time} == e, "R3/R4 action kind/msg/time",
                      int'({act_kind, act_msg, act_time}), int'(e));
            end
        end
        if (rst_n && cfg_err) cfg_seen++;
    end

    task automatic write_trg(input int a, input int k, input int m, input logic [6:0] c, input int mk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_kind = 3'(k); wr_msg = 6'(m); wr_code = c; wr_mark = 16'(mk);
        t_kind[a] = 3'(k); t_msg[a] = 6'(m); t_code[a] = c; t_mark[a] = 16'(mk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: starts a basic cycle and pushes the expected actions
    task automatic start_cycle(input int cnt);
        @(negedge clk);
        sof_sync = 1'b1; sof_cycle = 6'(cnt);
        @(negedge clk);
        sof_sync = 1'b0;
        check(cyc_time == 16'd0, "R2 cycle time cleared", int'(cyc_time), 0);
        for (int i = 0; i < DEPTH; i++) begin
            if (t_kind[i] == 3'd0) break;
            if (!code_applies(t_code[i], cnt)) continue;
            if (t_mark[i] <= ref_len || (t_kind[i] == 3'd1 && t_msg[i] != 6'd1)) begin
                cfg_exp++;
                continue;
            end
            exp_q.push_back({t_kind[i], t_msg[i], t_mark[i]});
            if (t_kind[i] == 3'd2) tx_model++;
        end
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ntu_tick = 1'b1;
            @(negedge clk); ntu_tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic finish_cycle(input string tag);
        run_ticks(70);
        check(exp_q.size() == 0, {tag, " R3 all due actions seen"}, exp_q.size(), 0);
        check(cfg_seen == cfg_exp, {tag, " R6/R7 config error pulses"}, cfg_seen, cfg_exp);
        exp_q.delete();
    endtask

    initial begin
        #(200000 * 4);
        check(1'b0, "watchdog", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            t_kind[i] = '0; t_msg[i] = '0; t_code[i] = '0; t_mark[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(!act_valid && !cfg_err && !tx_err, "R10 outputs idle after reset",
              int'({act_valid, cfg_err, tx_err}), 0);
        check(cyc_time == 16'd0, "R10 cycle time zero after reset", int'(cyc_time), 0);
        // R10/R1: ticks before any start give no action (entries read as end-of-list)
        run_ticks(5);
        check(cyc_time == 16'd5, "R2 cycle time counts ticks", int'(cyc_time), 5);

        // R1: load the list; kinds 1 ref tx, 2 msg tx, 3 rx check, 4 watch, 0 end
        write_trg(0, 3, 3, 7'b0000001, 5);   // R6: mark inside reference
        write_trg(1, 2, 4, 7'b0000001, 20);  // every cycle
        write_trg(2, 3, 5, 7'b0000010, 30);  // even cycles
        write_trg(3, 2, 6, 7'b0010011, 40);  // cnt mod 16 == 3
        write_trg(4, 2, 7, 7'b0100101, 45);  // cnt mod 32 == 5
        write_trg(5, 4, 0, 7'b1000010, 50);  // cnt mod 64 == 2
        write_trg(6, 1, 1, 7'b0000001, 60);  // reference transmit
        write_trg(7, 0, 0, 7'b0000000, 0);   // R8 end of list
        write_trg(8, 2, 9, 7'b0000001, 62);  // beyond end: must stay silent
        t_kind[8] = 3'd2;

        exp_tx = 8'd0;
        foreach (t_kind[i]) ;
        // First matrix run: cycles 0,1,2,3,5,19 (R4 codes)
        start_cycle(0);  tx_model = 1; finish_cycle("c0");
        start_cycle(1);  finish_cycle("c1");
        start_cycle(2);  finish_cycle("c2");
        start_cycle(3);  finish_cycle("c3");
        start_cycle(5);  finish_cycle("c5");
        start_cycle(19); finish_cycle("c19");

        // R9: matching count at matrix boundary
        exp_tx = 8'(tx_model);
        tx_model = 0;
        start_cycle(0);
        check(tx_err == 1'b0, "R9 count matches expected", int'(tx_err), 0);
        finish_cycle("m2c0");
        start_cycle(1);  finish_cycle("m2c1");

        // R7: reference trigger with wrong message number
        write_trg(6, 1, 2, 7'b0000001, 60);
        start_cycle(2);  finish_cycle("m2c2");

        // R9: mismatching count
        exp_tx = 8'(tx_model + 1);
        tx_model = 0;
        start_cycle(0);
        check(tx_err == 1'b1, "R9 count mismatch flagged", int'(tx_err), 1);
        finish_cycle("m3c0");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule